// File: doc/BRIEF.md
# Motion Sensor Serial Register Port

This block is the device side of a three-wire synchronous serial link for a motion-sensing peripheral. A host selects the device with an active-low select, clocks it with a serial clock and exchanges bits over one shared data line. The block decodes address bytes and serves single-register reads and writes to a small register file. It accumulates motion reports that arrive on a parallel snapshot interface, and it offers an address-free burst readout of the motion and image-quality values.

All serial inputs are brought into the system clock domain by synchronizers and are oversampled there. The data line leaves the block as a data bit plus an output-enable, which the pad ring turns into a tri-state driver. Two commands reset the port: a key written to a command register, and the reset pin. A control bit puts the port into power-down.

Top module: `motion_serial_port`

## Requirements
- R1: A transaction opens with an address byte, sent MSB first, whose bit 7 is 0 for a read and 1 for a write and whose bits 6:0 hold the register address. Input bits are sampled on rising serial-clock edges. Read data goes out MSB first, with each bit changed on a falling edge, starting at the falling edge that follows the eighth address bit. Map: 0x00 identity (parameter, default 0x5E), 0x02 delta X, 0x03 delta Y, 0x04 surface quality, 0x05/0x06 shutter high/low byte, 0x07 peak pixel, 0x08 pixel sum, 0x0D control, 0x20 scratch. Unmapped addresses read 0x00.
- R2: A write address byte followed by one data byte updates the control (0x0D) or scratch (0x20) register, which read back the written value. Several transactions may follow one another in a single select period.
- R3: Each motion report adds its signed 8-bit X and Y increments to two accumulators that saturate at +127 (0x7F) and -128 (0x80). A read of delta X or delta Y, single or in a burst, clears that accumulator. A report that arrives in the same cycle as the clear is kept.
- R4: A read of address 0x63 streams seven bytes back to back with no further address: delta X, delta Y, surface quality, shutter high, shutter low, peak pixel, pixel sum.
- R5: The seven burst values are frozen when the last address bit arrives. Later motion reports or changes on the snapshot inputs do not alter the stream in progress.
- R6: Raising select at any point during a burst ends it, and the output enable drops.
- R7: After a burst has started, the port ignores all traffic, including writes, reads and new bursts, and keeps the output enable low. This lasts until select has stayed high for EXIT_CLKS consecutive system clocks (default 16). A shorter high pulse does not unlock it.
- R8: Writing 0x5A to address 0x3A returns every register and accumulator to its default (all zero). Any other value written there has no effect.
- R9: Holding the synchronous active-low reset pin low has the same effect as R8 and also returns the port to idle with the output enable low.
- R10: Setting bit 1 of control (0x0D) enters power-down. In power-down every read returns 0x00 with the line driven, and address 0x63 acts as a plain one-byte read that does not lock the port. Only the 0x3A key write (R8) or the reset pin (R9) leaves power-down.
- R11: While select is high, serial-clock and data activity has no effect. The output enable is low whenever no read byte is being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial link |
| rst_n | input | 1 | Synchronous active-low full reset |
| cs_n | input | 1 | Active-low device select |
| sclk | input | 1 | Serial clock, idles high |
| sdio_in | input | 1 | Data line as seen by the input buffer |
| sdio_out | output | 1 | Data bit to drive onto the line |
| sdio_oe | output | 1 | Drive enable for the data line |
| mot_valid | input | 1 | One-cycle strobe for a motion report |
| mot_dx | input | 8 | Signed X increment of the report |
| mot_dy | input | 8 | Signed Y increment of the report |
| squal | input | 8 | Live surface quality value |
| shutter | input | 16 | Live shutter value |
| max_pix | input | 8 | Live peak pixel value |
| pix_sum | input | 8 | Live pixel sum value |

## Verification
The bench changes the snapshot inputs and injects motion right after the burst address. A design that loaded the stream late, or byte by byte, would return the new values and not the frozen ones. It pulses select high for fewer clocks than the exit time and then tries a write. A port that unlocked on any select edge would take that write and show it on the next read of the scratch register. Truncated bursts, saturation at both ends, a wrong reset key and the burst address in power-down are also exercised. A port that cleared the wrong accumulator, wrapped instead of clamping, reset on any key, or locked up in power-down would read back the wrong byte or keep the line undriven.

// File: rtl/spx_pkg.sv
// Shared constants and types for the motion serial port.
// Assumes byte-wide registers and a seven-byte burst.
package spx_pkg;
    localparam int BYTE_W      = 8;
    localparam int ADDR_W      = 7;
    localparam int BURST_BYTES = 7;
    localparam int TX_W        = BURST_BYTES * BYTE_W;
    localparam int CNT_W       = $clog2(TX_W + 1);
    localparam int PD_BIT      = 1;

    localparam logic [ADDR_W-1:0] A_ID      = 7'h00;
    localparam logic [ADDR_W-1:0] A_DX      = 7'h02;
    localparam logic [ADDR_W-1:0] A_DY      = 7'h03;
    localparam logic [ADDR_W-1:0] A_SQUAL   = 7'h04;
    localparam logic [ADDR_W-1:0] A_SHUT_HI = 7'h05;
    localparam logic [ADDR_W-1:0] A_SHUT_LO = 7'h06;
    localparam logic [ADDR_W-1:0] A_MAXPIX  = 7'h07;
    localparam logic [ADDR_W-1:0] A_PIXSUM  = 7'h08;
    localparam logic [ADDR_W-1:0] A_CTRL    = 7'h0D;
    localparam logic [ADDR_W-1:0] A_SCRATCH = 7'h20;
    localparam logic [ADDR_W-1:0] A_SRST    = 7'h3A;
    localparam logic [ADDR_W-1:0] A_BURST   = 7'h63;

    localparam logic [BYTE_W-1:0] SRST_KEY  = 8'h5A;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WDATA,
        ST_XMIT,
        ST_LOCK
    } port_state_t;
endpackage

// File: rtl/msp_sync.sv
// Multi-bit input synchronizer: every bit passes through its own chain
// of STAGES flops. Assumes each bit is independent (no bus coherence)
// and STAGES >= 2. Reset loads each chain with its idle level.
module msp_sync #(
    parameter int               WIDTH    = 3,
    parameter int               STAGES   = 2,
    parameter logic [WIDTH-1:0] IDLE_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the raw input through the metastability chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{IDLE_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], async_in[g]};
        end

        assign sync_out[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/msp_regs.sv
// Register file of the motion port: saturating motion accumulators,
// control and scratch registers, a live snapshot of image values and
// the burst vector. Assumes write and read strobes are single-cycle
// pulses from the serial engine. Soft reset and pin reset are synchronous.
module msp_regs
    import spx_pkg::*;
#(
    parameter logic [BYTE_W-1:0] ID_VALUE = 8'h5E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_take,
    input  logic              burst_take,
    input  logic              mot_valid,
    input  logic [BYTE_W-1:0] mot_dx,
    input  logic [BYTE_W-1:0] mot_dy,
    input  logic [BYTE_W-1:0] squal,
    input  logic [15:0]       shutter,
    input  logic [BYTE_W-1:0] max_pix,
    input  logic [BYTE_W-1:0] pix_sum,
    output logic [BYTE_W-1:0] rd_data,
    output logic [TX_W-1:0]   burst_vec,
    output logic              pd
);
    logic [BYTE_W-1:0] dx_q, dy_q, ctrl_q, scratch_q;
    logic [BYTE_W-1:0] dx_base, dy_base, dx_next, dy_next;
    logic              soft_rst, clr_dx, clr_dy;

    // Signed add of two bytes, clamped to the byte range.
    function automatic logic [BYTE_W-1:0] sat_add(input logic [BYTE_W-1:0] a,
                                                  input logic [BYTE_W-1:0] b);
        logic signed [BYTE_W:0] s;
        s = $signed({a[BYTE_W-1], a}) + $signed({b[BYTE_W-1], b});
        if (s > $signed(9'sd127))       return 8'h7F;
        else if (s < -$signed(9'sd128)) return 8'h80;
        else                            return s[BYTE_W-1:0];
    endfunction

    assign pd       = ctrl_q[PD_BIT];
    assign soft_rst = wr_en && (wr_addr == A_SRST) && (wr_data == SRST_KEY);
    assign clr_dx   = !pd && ((rd_take && rd_addr == A_DX) || burst_take);
    assign clr_dy   = !pd && ((rd_take && rd_addr == A_DY) || burst_take);

    // Next accumulator values: clear first, then add a coincident report.
    always_comb begin
        dx_base = clr_dx ? '0 : dx_q;
        dy_base = clr_dy ? '0 : dy_q;
        dx_next = mot_valid ? sat_add(dx_base, mot_dx) : dx_base;
        dy_next = mot_valid ? sat_add(dy_base, mot_dy) : dy_base;
    end

    // Register state: reset by pin or key, otherwise update.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            dx_q      <= '0;
            dy_q      <= '0;
            ctrl_q    <= '0;
            scratch_q <= '0;
        end else begin
            dx_q <= dx_next;
            dy_q <= dy_next;
            if (wr_en && !pd) begin
                if (wr_addr == A_CTRL)    ctrl_q    <= wr_data;
                if (wr_addr == A_SCRATCH) scratch_q <= wr_data;
            end
        end
    end

    // Read multiplexer; everything reads zero in power-down.
    always_comb begin
        rd_data = '0;
        if (!pd) begin
            case (rd_addr)
                A_ID:      rd_data = ID_VALUE;
                A_DX:      rd_data = dx_q;
                A_DY:      rd_data = dy_q;
                A_SQUAL:   rd_data = squal;
                A_SHUT_HI: rd_data = shutter[15:8];
                A_SHUT_LO: rd_data = shutter[7:0];
                A_MAXPIX:  rd_data = max_pix;
                A_PIXSUM:  rd_data = pix_sum;
                A_CTRL:    rd_data = ctrl_q;
                A_SCRATCH: rd_data = scratch_q;
                default:   rd_data = '0;
            endcase
        end
    end

    // Burst payload in stream order, first byte in the top bits.
    assign burst_vec = {dx_q, dy_q, squal, shutter[15:8], shutter[7:0], max_pix, pix_sum};

    // R3
    dx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take && rd_addr == A_DX && !pd && !mot_valid && !soft_rst) |=> (dx_q == '0));

    // R8
    key_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_SRST && wr_data == SRST_KEY) |=>
            (ctrl_q == '0 && scratch_q == '0 && dx_q == '0 && dy_q == '0));

    // R10
    pd_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd && !(wr_en && wr_addr == A_SRST && wr_data == SRST_KEY)) |=>
            ($stable(scratch_q) && pd));
endmodule

// File: rtl/msp_engine.sv
// Serial protocol engine. Runs in the system clock domain on
// synchronized inputs, detects serial-clock edges, decodes address
// bytes, issues read/write strobes, shifts read data out on falling
// edges and enforces the post-burst lockout. Assumes the system clock
// is at least eight times faster than the serial clock.
module msp_engine
    import spx_pkg::*;
#(
    parameter int EXIT_CLKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              din_s,
    input  logic              pd,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic [TX_W-1:0]   burst_vec,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_take,
    output logic              burst_take,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sdo,
    output logic              oe
);
    localparam int               EXIT_W      = $clog2(EXIT_CLKS + 1);
    localparam logic [EXIT_W-1:0] EXIT_LAST  = EXIT_W'(EXIT_CLKS - 1);
    localparam logic [CNT_W-1:0] LAST_BYTE   = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] LAST_BURST  = CNT_W'(TX_W - 1);

    port_state_t       state;
    logic              sclk_d, rise, fall, cs_act, addr_done, burst_hit, last_bit;
    logic [BYTE_W-1:0] sh_q, addr_full;
    logic [CNT_W-1:0]  bit_cnt;
    logic [TX_W-1:0]   tx_q;
    logic              locked;
    logic [EXIT_W-1:0] exit_cnt;

    assign cs_act     = ~cs_n_s;
    assign rise       = sclk_s & ~sclk_d;
    assign fall       = ~sclk_s & sclk_d;
    assign addr_full  = {sh_q[BYTE_W-2:0], din_s};
    assign addr_done  = cs_act && (state == ST_ADDR) && rise && (bit_cnt == LAST_BYTE);
    assign burst_hit  = (addr_full[ADDR_W-1:0] == A_BURST) && !pd;
    assign rd_addr    = addr_full[ADDR_W-1:0];
    assign rd_take    = addr_done && !addr_full[BYTE_W-1] && !burst_hit;
    assign burst_take = addr_done && !addr_full[BYTE_W-1] && burst_hit;
    assign last_bit   = bit_cnt == (locked ? LAST_BURST : LAST_BYTE);

    // Previous serial-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b1;
        else        sclk_d <= sclk_s;
    end

    // Lockout after a burst: cleared only by a long enough deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked   <= 1'b0;
            exit_cnt <= '0;
        end else if (burst_take) begin
            locked   <= 1'b1;
            exit_cnt <= '0;
        end else if (cs_act) begin
            exit_cnt <= '0;
        end else if (locked) begin
            if (exit_cnt == EXIT_LAST) begin
                locked   <= 1'b0;
                exit_cnt <= '0;
            end else begin
                exit_cnt <= exit_cnt + 1'b1;
            end
        end
    end

    // Transaction state machine, shifters and output drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            sh_q    <= '0;
            bit_cnt <= '0;
            tx_q    <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            sdo     <= 1'b0;
            oe      <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (!cs_act) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
                oe      <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE: begin
                        state   <= locked ? ST_LOCK : ST_ADDR;
                        bit_cnt <= '0;
                    end
                    ST_ADDR: begin
                        if (rise) begin
                            sh_q <= addr_full;
                            if (bit_cnt == LAST_BYTE) begin
                                bit_cnt <= '0;
                                if (addr_full[BYTE_W-1]) begin
                                    wr_addr <= addr_full[ADDR_W-1:0];
                                    state   <= ST_WDATA;
                                end else if (burst_hit) begin
                                    tx_q  <= burst_vec;
                                    state <= ST_XMIT;
                                end else begin
                                    tx_q  <= {rd_data, {(TX_W-BYTE_W){1'b0}}};
                                    state <= ST_XMIT;
                                end
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (rise) begin
                            sh_q <= addr_full;
                            if (bit_cnt == LAST_BYTE) begin
                                bit_cnt <= '0;
                                wr_en   <= 1'b1;
                                wr_data <= addr_full;
                                state   <= ST_ADDR;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_XMIT: begin
                        if (fall) begin
                            sdo  <= tx_q[TX_W-1];
                            tx_q <= {tx_q[TX_W-2:0], 1'b0};
                            oe   <= 1'b1;
                        end
                        if (rise) begin
                            if (last_bit) begin
                                bit_cnt <= '0;
                                oe      <= 1'b0;
                                state   <= locked ? ST_LOCK : ST_ADDR;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    default: begin
                        oe <= 1'b0;
                    end
                endcase
            end
        end
    end

    // R11
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !oe);

    // R7
    lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && state == ST_LOCK) |=> (!oe && !wr_en));

    // R5
    burst_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_take |=> (state == ST_XMIT && tx_q == $past(burst_vec)));
endmodule

// File: rtl/motion_serial_port.sv
// Top level of the motion serial port: input synchronizers, protocol
// engine and register file. Assumes sclk idles high and that the pad
// ring builds the tri-state data line from sdio_out and sdio_oe.
module motion_serial_port
    import spx_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter int                EXIT_CLKS   = 16,
    parameter logic [BYTE_W-1:0] ID_VALUE    = 8'h5E
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        sclk,
    input  logic        sdio_in,
    output logic        sdio_out,
    output logic        sdio_oe,
    input  logic        mot_valid,
    input  logic [7:0]  mot_dx,
    input  logic [7:0]  mot_dy,
    input  logic [7:0]  squal,
    input  logic [15:0] shutter,
    input  logic [7:0]  max_pix,
    input  logic [7:0]  pix_sum
);
    logic [2:0]        pins_s;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [BYTE_W-1:0] rd_data, wr_data;
    logic [TX_W-1:0]   burst_vec;
    logic              rd_take, burst_take, wr_en, pd;

    msp_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .IDLE_VAL(3'b011)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in({sdio_in, cs_n, sclk}),
        .sync_out(pins_s)
    );

    msp_engine #(
        .EXIT_CLKS(EXIT_CLKS)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (pins_s[0]),
        .cs_n_s    (pins_s[1]),
        .din_s     (pins_s[2]),
        .pd        (pd),
        .rd_data   (rd_data),
        .burst_vec (burst_vec),
        .rd_addr   (rd_addr),
        .rd_take   (rd_take),
        .burst_take(burst_take),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sdo       (sdio_out),
        .oe        (sdio_oe)
    );

    msp_regs #(
        .ID_VALUE(ID_VALUE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_take   (rd_take),
        .burst_take(burst_take),
        .mot_valid (mot_valid),
        .mot_dx    (mot_dx),
        .mot_dy    (mot_dy),
        .squal     (squal),
        .shutter   (shutter),
        .max_pix   (max_pix),
        .pix_sum   (pix_sum),
        .rd_data   (rd_data),
        .burst_vec (burst_vec),
        .pd        (pd)
    );
endmodule

// File: tb/sim_motion_serial_port.sv
// Directed bench for motion_serial_port: one task per scenario.
module sim_motion_serial_port;
    localparam int CLK_PERIOD = 10;
    localparam int SH         = 8;
    localparam int EXIT       = 16;
    localparam logic [7:0] ID = 8'h5E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic        sdio_in = 1'b0;
    logic        sdio_out, sdio_oe;
    logic        mot_valid = 1'b0;
    logic [7:0]  mot_dx = '0, mot_dy = '0;
    logic [7:0]  squal = 8'h00, max_pix = 8'h00, pix_sum = 8'h00;
    logic [15:0] shutter = 16'h0000;

    int n_chk = 0;
    int n_err = 0;
    int mdx = 0;
    int mdy = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    motion_serial_port #(.EXIT_CLKS(EXIT), .ID_VALUE(ID)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .mot_valid(mot_valid),
        .mot_dx(mot_dx), .mot_dy(mot_dy), .squal(squal), .shutter(shutter),
        .max_pix(max_pix), .pix_sum(pix_sum)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
        end
    endtask

    function automatic int clamp(input int v);
        if (v > 127)  return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                        output logic oe_all, output logic oe_any);
        oe_all = 1'b1;
        oe_any = 1'b0;
        rx = '0;
        for (int i = 7; i >= 0; i--) begin
            sclk = 1'b0;
            sdio_in = tx[i];
            wait_clk(SH);
            rx[i] = sdio_out;
            oe_all = oe_all & sdio_oe;
            oe_any = oe_any | sdio_oe;
            sclk = 1'b1;
            wait_clk(SH);
        end
    endtask

    task automatic sel_on();
        cs_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic sel_off(input int gap);
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(gap);
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] d, output logic oe_all);
        logic [7:0] dummy;
        logic a1, a2, any;
        sel_on();
        xfer({1'b0, a}, dummy, a1, a2);
        xfer(8'h00, d, oe_all, any);
        sel_off(EXIT + 8);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        logic [7:0] dummy;
        logic a1, a2;
        sel_on();
        xfer({1'b1, a}, dummy, a1, a2);
        xfer(d, dummy, a1, a2);
        sel_off(EXIT + 8);
    endtask

    task automatic push(input int x, input int y);
        mot_dx = 8'(x);
        mot_dy = 8'(y);
        mot_valid = 1'b1;
        wait_clk(1);
        mot_valid = 1'b0;
        wait_clk(1);
        mdx = clamp(mdx + x);
        mdy = clamp(mdy + y);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        logic oe;
        chk("R11", "oe after reset", {7'b0, sdio_oe}, 8'h00);
        rd(7'h00, d, oe);
        chk("R1", "identity", d, ID);
        chk("R1", "read drives line", {7'b0, oe}, 8'h01);
        rd(7'h20, d, oe);
        chk("R9", "scratch default", d, 8'h00);
        rd(7'h02, d, oe);
        chk("R9", "dx default", d, 8'h00);
    endtask

    task automatic t_single_rw();
        logic [7:0] d, dummy;
        logic oe, a1, a2;
        wr(7'h20, 8'hA5);
        rd(7'h20, d, oe);
        chk("R2", "scratch write", d, 8'hA5);
        wr(7'h0D, 8'h01);
        rd(7'h0D, d, oe);
        chk("R2", "control write", d, 8'h01);
        wr(7'h0D, 8'h00);
        rd(7'h11, d, oe);
        chk("R1", "unmapped read", d, 8'h00);
        squal = 8'h42;
        shutter = 16'hBEEF;
        rd(7'h04, d, oe);
        chk("R1", "surface quality", d, 8'h42);
        rd(7'h06, d, oe);
        chk("R1", "shutter low", d, 8'hEF);
        // R2: write then read in one select period
        sel_on();
        xfer(8'hA0, dummy, a1, a2);
        xfer(8'h5C, dummy, a1, a2);
        xfer(8'h20, dummy, a1, a2);
        xfer(8'h00, d, a1, a2);
        sel_off(EXIT + 8);
        chk("R2", "back-to-back write/read", d, 8'h5C);
        wr(7'h20, 8'hA5);
    endtask

    task automatic t_motion();
        logic [7:0] d;
        logic oe;
        push(100, -100);
        push(50, -100);
        rd(7'h02, d, oe);
        chk("R3", "dx saturates high", d, 8'(mdx));
        mdx = 0;
        rd(7'h02, d, oe);
        chk("R3", "dx cleared by read", d, 8'h00);
        rd(7'h03, d, oe);
        chk("R3", "dy saturates low", d, 8'h80);
        mdy = 0;
        push(-5, 0);
        push(2, 0);
        rd(7'h02, d, oe);
        chk("R3", "dx signed sum", d, 8'hFD);
        mdx = 0;
    endtask

    task automatic t_burst_full();
        logic [7:0] d, dummy;
        logic a1, a2;
        logic [7:0] exp_b [7];
        squal = 8'h33; shutter = 16'h1234; max_pix = 8'h9A; pix_sum = 8'h77;
        push(5, -3);
        exp_b = '{8'(mdx), 8'(mdy), 8'h33, 8'h12, 8'h34, 8'h9A, 8'h77};
        sel_on();
        xfer(8'h63, dummy, a1, a2);
        squal = 8'hEE; pix_sum = 8'h11;
        mdx = 0; mdy = 0;
        push(7, 2);
        for (int i = 0; i < 7; i++) begin
            xfer(8'h00, d, a1, a2);
            chk("R4", $sformatf("burst byte %0d (R5 frozen)", i), d, exp_b[i]);
            chk("R4", $sformatf("burst byte %0d driven", i), {7'b0, a1}, 8'h01);
        end
        // R7: still selected after the stream, the port must stay silent
        xfer(8'hA0, dummy, a1, a2);
        xfer(8'h3C, dummy, a1, a2);
        xfer(8'h20, dummy, a1, a2);
        xfer(8'h00, d, a1, a2);
        chk("R7", "no drive while locked", {7'b0, a2}, 8'h00);
        cs_n = 1'b1;
        wait_clk(5);
        cs_n = 1'b0;
        wait_clk(4);
        xfer(8'hA0, dummy, a1, a2);
        xfer(8'h3C, dummy, a1, a2);
        xfer(8'h63, dummy, a1, a2);
        xfer(8'h00, d, a1, a2);
        chk("R7", "short deselect keeps lock", {7'b0, a2}, 8'h00);
        sel_off(EXIT + 8);
        rd(7'h20, d, a1);
        chk("R7", "locked writes ignored", d, 8'hA5);
        wr(7'h20, 8'h3C);
        rd(7'h20, d, a1);
        chk("R7", "port usable after exit", d, 8'h3C);
        rd(7'h02, d, a1);
        chk("R5", "dx after burst", d, 8'(mdx));
        rd(7'h03, d, a1);
        chk("R5", "dy after burst", d, 8'(mdy));
        mdx = 0; mdy = 0;
    endtask

    task automatic t_burst_cut();
        logic [7:0] d, dummy;
        logic a1, a2;
        push(9, 0);
        sel_on();
        xfer(8'h63, dummy, a1, a2);
        xfer(8'h00, d, a1, a2);
        chk("R4", "cut burst byte 0", d, 8'h09);
        xfer(8'h00, d, a1, a2);
        chk("R4", "cut burst byte 1", d, 8'h00);
        cs_n = 1'b1;
        wait_clk(6);
        chk("R6", "oe drops on deselect", {7'b0, sdio_oe}, 8'h00);
        wait_clk(EXIT + 8);
        mdx = 0;
        rd(7'h02, d, a1);
        chk("R3", "dx cleared by burst", d, 8'h00);
        rd(7'h20, d, a1);
        chk("R6", "port usable after cut", d, 8'h3C);
    endtask

    task automatic t_soft_reset();
        logic [7:0] d;
        logic oe;
        wr(7'h3A, 8'h11);
        rd(7'h20, d, oe);
        chk("R8", "wrong key ignored", d, 8'h3C);
        push(20, 20);
        wr(7'h0D, 8'h01);
        wr(7'h3A, 8'h5A);
        mdx = 0; mdy = 0;
        rd(7'h20, d, oe);
        chk("R8", "scratch after key", d, 8'h00);
        rd(7'h0D, d, oe);
        chk("R8", "control after key", d, 8'h00);
        rd(7'h02, d, oe);
        chk("R8", "dx after key", d, 8'h00);
    endtask

    task automatic t_power_down();
        logic [7:0] d, dummy;
        logic oe, a1, a2;
        wr(7'h20, 8'h66);
        wr(7'h0D, 8'h02);
        rd(7'h00, d, oe);
        chk("R10", "identity reads zero", d, 8'h00);
        chk("R10", "line driven", {7'b0, oe}, 8'h01);
        sel_on();
        xfer(8'h63, dummy, a1, a2);
        xfer(8'h00, d, a1, a2);
        chk("R10", "burst address single byte", d, 8'h00);
        xfer(8'h20, dummy, a1, a2);
        xfer(8'h00, d, a1, a2);
        sel_off(EXIT + 8);
        chk("R10", "no lock in power-down", {7'b0, a1}, 8'h01);
        chk("R10", "scratch reads zero", d, 8'h00);
        wr(7'h3A, 8'h5A);
        rd(7'h00, d, oe);
        chk("R10", "awake after key", d, ID);
        rd(7'h20, d, oe);
        chk("R10", "scratch reset on exit", d, 8'h00);
    endtask

    task automatic t_pin_reset();
        logic [7:0] d;
        logic oe;
        wr(7'h20, 8'h77);
        push(3, 3);
        rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(3);
        mdx = 0; mdy = 0;
        chk("R9", "oe low after pin reset", {7'b0, sdio_oe}, 8'h00);
        rd(7'h20, d, oe);
        chk("R9", "scratch after pin reset", d, 8'h00);
        rd(7'h03, d, oe);
        chk("R9", "dy after pin reset", d, 8'h00);
    endtask

    task automatic t_cs_high();
        logic [7:0] d, dummy;
        logic oe, a1, a2;
        xfer(8'hA0, dummy, a1, a2);
        xfer(8'hFF, dummy, a1, a2);
        xfer(8'h00, dummy, a1, a2);
        chk("R11", "no drive while deselected", {7'b0, a2}, 8'h00);
        wait_clk(4);
        rd(7'h20, d, oe);
        chk("R11", "clocks ignored while deselected", d, 8'h00);
    endtask

    initial begin : main
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_single_rw();
        t_motion();
        t_burst_full();
        t_burst_cut();
        t_soft_reset();
        t_power_down();
        t_pin_reset();
        t_cs_high();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule